// File: doc/BRIEF.md
# Four-wire serial register port

This block is the slave side of a four-wire serial control port. A host selects the device with an active-low chip select and clocks 24-bit frames in on a serial data input. It reads results back on a separate serial data output. Each frame opens with a direction bit, then a 7-bit register address, then a 16-bit data word. All fields go most significant bit first. Write frames load the addressed entry of an internal bank of 128 sixteen-bit registers. Read frames return that entry on the data-out line.

The serial pins are sampled by a fast system clock through synchronisers, so the port needs no second clock domain. The data-out pin is modelled as a value plus an output-enable for an external pad. A configuration input selects one of two idle behaviours for that pin. In push-pull mode it is held low when it carries no data. In open-drain mode it is released when it carries no data, and a 1 is sent by leaving the line to its pull-up. Two mode-select inputs must both be high for the port to operate.

Top module: `spi4_ctl_port`

## Requirements
- R1: A frame is one direction bit (0 = write, 1 = read), address bits A6..A0, then data bits B15..B0, each sampled on a rising edge of `sclk_i`. A write frame stores the 16 data bits into the addressed register on the 24th rising edge.
- R2: In a read frame, data bit B15 appears on the line after the falling edge that follows the rising edge that captured A0. Each later falling edge presents the next lower bit. B0 stays on the line until the next falling edge or until chip select rises.
- R3: The port operates only when `mode_3w_i` and `mode_4w_i` are both 1. With any other setting, `sdo_oe_o` and `sdo_o` stay 0, frames are ignored and no register is written.
- R4: In push-pull mode (`od_mode_i` = 0), `sdo_oe_o` is 1 at all times and `sdo_o` is 0 except while a read data bit of value 1 is on the line.
- R5: In open-drain mode (`od_mode_i` = 1), `sdo_o` is always 0. `sdo_oe_o` is 1 only while a read data bit of value 0 is on the line. It is 0 for data bits of value 1 and outside the 16 data bit periods.
- R6: A rise of `csb_i` aborts the frame and clears the bit position. A write frame that ends before its 24th rising edge changes no register.
- R7: In a read frame, `sdi_i` has no effect after the address is captured. The register contents and the returned bits do not depend on it.
- R8: The register bank holds 128 registers that reset to 0. A read of any address returns the last value written there.
- R9: Rising edges after the 24th in one frame are ignored. They cause no second write, and the line returns to idle after the falling edge that follows the 24th rising edge.
- R10: The serial inputs pass through a two-stage synchroniser. `sdo_o` and `sdo_oe_o` change at the third rising edge of `clk_i` after a falling edge of `sclk_i` or a rising edge of `csb_i` is presented. Each `sclk_i` phase must last at least 3 `clk_i` periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples the serial pins |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_3w_i | input | 1 | Mode-select bit one; must be 1 for four-wire operation |
| mode_4w_i | input | 1 | Mode-select bit two; must be 1 for four-wire operation |
| od_mode_i | input | 1 | Data-out idle behaviour: 0 push-pull, 1 open-drain |
| csb_i | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial clock from the host |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out enable for the pad |

## Verification
The bench aims at the hand-off from address to data. A port that launched B15 one falling edge late would shift every read word by one bit. A port that went on sampling the data input during a read would let junk on that line corrupt later reads. It also truncates write frames at 20 bits and overruns them to 30 bits. A port that committed early, or wrote again on the overrun, would leave a wrong value in the register bank. Both idle polarities and all three non-operating mode settings are run. An open-drain port that drove a 1 high, or a disabled port that still drove the pin, is caught by the cycle compare.

// File: rtl/spi4_pkg.sv
package spi4_pkg;
  localparam int ADDR_W    = 7;
  localparam int DATA_W    = 16;
  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int SYNC_N    = 2;
endpackage

// File: rtl/spi4_in_sync.sv
module spi4_in_sync #(
  parameter int STAGES = spi4_pkg::SYNC_N
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic csb_i,
  input  logic sdi_i,
  output logic csb_s_o,
  output logic sdi_s_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int W = 3;
  localparam logic [W-1:0] RST_VAL = 3'b010; // {sdi, csb, sclk}

  logic [W-1:0] raw;
  logic [W-1:0] syn;
  logic         sclk_d_q;

  assign raw = {sdi_i, csb_i, sclk_i};

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= {STAGES{RST_VAL[i]}};
      else         ff_q <= {ff_q[STAGES-2:0], raw[i]};
    end
    assign syn[i] = ff_q[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_d_q <= 1'b0;
    else         sclk_d_q <= syn[0];
  end

  assign rise_o  = syn[0] & ~sclk_d_q;
  assign fall_o  = ~syn[0] & sclk_d_q;
  assign csb_s_o = syn[1];
  assign sdi_s_o = syn[2];
endmodule

// File: rtl/spi4_frame.sv
module spi4_frame
  import spi4_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   csb_s_i,
  input  logic                   sdi_s_i,
  input  logic                   rise_i,
  input  logic                   fall_i,
  input  logic [DW-1:0]          rd_data_i,
  output logic [AW-1:0]          addr_o,
  output logic                   wr_en_o,
  output logic [DW-1:0]          wr_data_o,
  output logic [CNT_W-1:0]       cnt_o,
  output logic                   dat_vld_o,
  output logic                   dat_bit_o
);
  localparam int LEN   = 1 + AW + DW;
  localparam int IDX_W = $clog2(DW);

  logic [CNT_W-1:0] cnt_q;
  logic             dir_q;
  logic [AW-1:0]    addr_q;
  logic [DW-2:0]    wsh_q;
  logic             vld_q, bit_q;
  logic             live;
  logic [IDX_W-1:0] bit_idx;

  assign live    = en_i & ~csb_s_i;
  // LEN-1 and cnt_q agree modulo DW, so the low bits give the data index
  assign bit_idx = IDX_W'(LEN - 1) - IDX_W'(cnt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      dir_q  <= 1'b0;
      addr_q <= '0;
      wsh_q  <= '0;
      vld_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else if (!live) begin
      cnt_q <= '0;
      vld_q <= 1'b0;
    end else begin
      if (rise_i && cnt_q != CNT_W'(LEN)) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == '0)                 dir_q  <= sdi_s_i;
        else if (cnt_q <= CNT_W'(AW))    addr_q <= {addr_q[AW-2:0], sdi_s_i};
        else if (!dir_q)                 wsh_q  <= {wsh_q[DW-3:0], sdi_s_i};
      end
      if (fall_i) begin
        vld_q <= dir_q && (cnt_q > CNT_W'(AW)) && (cnt_q < CNT_W'(LEN));
        bit_q <= rd_data_i[bit_idx];
      end
    end
  end

  assign wr_en_o   = live & rise_i & ~dir_q & (cnt_q == CNT_W'(LEN - 1));
  assign wr_data_o = {wsh_q, sdi_s_i};
  assign addr_o    = addr_q;
  assign cnt_o     = cnt_q;
  assign dat_vld_o = vld_q;
  assign dat_bit_o = bit_q;
endmodule

// File: rtl/spi4_regfile.sv
module spi4_regfile #(
  parameter int AW = spi4_pkg::ADDR_W,
  parameter int DW = spi4_pkg::DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] rows;

  for (genvar r = 0; r < DEPTH; r++) begin : g_row
    logic [DW-1:0] row_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           row_q <= '0;
      else if (we_i && addr_i == AW'(r))     row_q <= wdata_i;
    end
    assign rows[r] = row_q;
  end

  assign rdata_o = rows[addr_i];
endmodule

// File: rtl/spi4_sdo_drv.sv
module spi4_sdo_drv (
  input  logic en_i,
  input  logic od_i,
  input  logic vld_i,
  input  logic bit_i,
  output logic sdo_o,
  output logic oe_o
);
  always_comb begin
    if (!en_i) begin
      sdo_o = 1'b0;
      oe_o  = 1'b0;
    end else if (od_i) begin
      sdo_o = 1'b0;            // open-drain: only ever pull low
      oe_o  = vld_i & ~bit_i;
    end else begin
      sdo_o = vld_i & bit_i;
      oe_o  = 1'b1;
    end
  end
endmodule

// File: rtl/spi4_ctl_port.sv
module spi4_ctl_port
  import spi4_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mode_3w_i,
  input  logic mode_4w_i,
  input  logic od_mode_i,
  input  logic csb_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  logic              mode4;
  logic              csb_s, sdi_s, rise, fall;
  logic [ADDR_W-1:0] addr;
  logic              wr_en;
  logic [DATA_W-1:0] wr_data, rd_data;
  logic [CNT_W-1:0]  cnt;
  logic              dat_vld, dat_bit;

  assign mode4 = mode_3w_i & mode_4w_i;

  spi4_in_sync u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sclk_i  (sclk_i),
    .csb_i   (csb_i),
    .sdi_i   (sdi_i),
    .csb_s_o (csb_s),
    .sdi_s_o (sdi_s),
    .rise_o  (rise),
    .fall_o  (fall)
  );

  spi4_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode4),
    .csb_s_i   (csb_s),
    .sdi_s_i   (sdi_s),
    .rise_i    (rise),
    .fall_i    (fall),
    .rd_data_i (rd_data),
    .addr_o    (addr),
    .wr_en_o   (wr_en),
    .wr_data_o (wr_data),
    .cnt_o     (cnt),
    .dat_vld_o (dat_vld),
    .dat_bit_o (dat_bit)
  );

  spi4_regfile u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en),
    .addr_i  (addr),
    .wdata_i (wr_data),
    .rdata_o (rd_data)
  );

  spi4_sdo_drv u_drv (
    .en_i  (mode4),
    .od_i  (od_mode_i),
    .vld_i (dat_vld),
    .bit_i (dat_bit),
    .sdo_o (sdo_o),
    .oe_o  (sdo_oe_o)
  );
endmodule

// File: rtl/spi4_ctl_port_chk.sv
module spi4_ctl_port_chk
  import spi4_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mode4_i,
  input logic             od_i,
  input logic             csb_s_i,
  input logic             sdo_i,
  input logic             oe_i,
  input logic             wr_en_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             vld_i
);
  assert_idle_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode4_i |-> (!oe_i && !sdo_i));

  assert_pp_drive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode4_i && !od_i) |-> oe_i);

  assert_pp_low_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode4_i && !od_i && !vld_i) |-> !sdo_i);

  assert_od_never_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_i |-> !sdo_i);

  assert_od_release_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode4_i && od_i && !vld_i) |-> !oe_i);

  assert_write_last_bit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (cnt_i == CNT_W'(FRAME_LEN)));

  assert_abort_clears_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csb_s_i |=> (cnt_i == '0 && !vld_i));

  assert_single_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> !wr_en_i);
endmodule

bind spi4_ctl_port spi4_ctl_port_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .mode4_i (mode4),
  .od_i    (od_mode_i),
  .csb_s_i (csb_s),
  .sdo_i   (sdo_o),
  .oe_i    (sdo_oe_o),
  .wr_en_i (wr_en),
  .cnt_i   (cnt),
  .vld_i   (dat_vld)
);

// File: tb/spi4_ctl_port_tb_top.sv
module spi4_ctl_port_tb_top;
  localparam int HALF = 4;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, m3, m4, od, csb, sclk, sdi;
  logic sdo, oe;

  spi4_ctl_port dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_3w_i (m3),
    .mode_4w_i (m4),
    .od_mode_i (od),
    .csb_i     (csb),
    .sclk_i    (sclk),
    .sdi_i     (sdi),
    .sdo_o     (sdo),
    .sdo_oe_o  (oe)
  );

  int    checks = 0;
  int    fails  = 0;
  int    cyc    = 0;
  bit    cmp_en = 0;
  string cur_req = "R8";

  logic [15:0] mem_m [128];
  logic        exp_vld, exp_bit;
  logic [1:0]  hist [3];

  function automatic logic [1:0] ideal();
    if (!(m3 && m4)) return 2'b00;
    if (od)          return {exp_vld & ~exp_bit, 1'b0};
    return {1'b1, exp_vld & exp_bit};
  endfunction

  // R10: outputs follow the ideal pin value two clocks behind the posedge it is recorded at
  always @(posedge clk) begin
    cyc++;
    hist[2] = hist[1];
    hist[1] = hist[0];
    hist[0] = ideal();
    if (cyc == WDOG) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (cmp_en) begin
      checks++;
      if ({oe, sdo} !== hist[2]) begin
        fails++;
        $display("FAIL R10 (%s) cycle %0d: oe,sdo=%b%b expected %b", cur_req, cyc, oe, sdo, hist[2]);
      end
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic a, input logic b, input logic o);
    cmp_en = 0;
    m3 = a; m4 = b; od = o; exp_vld = 1'b0;
    for (int i = 0; i < 3; i++) hist[i] = ideal();
    repeat (2) @(negedge clk);
    cmp_en = 1;
  endtask

  task automatic frame(input bit rd, input logic [6:0] a, input logic [15:0] d,
                       input int nbits, output logic [15:0] got);
    logic [23:0] s;
    logic [15:0] w;
    bit act;
    s = {rd, a, d};
    w = mem_m[a];
    act = m3 && m4;
    got = '0;
    csb = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int k = 1; k <= nbits; k++) begin
      sdi = (k <= 24) ? s[24-k] : k[0];
      repeat (HALF) @(negedge clk);
      if (rd && k >= 9 && k <= 24) got[24-k] = od ? ~oe : sdo;
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
      if (act && rd && k >= 8 && k <= 23) begin
        exp_vld = 1'b1; exp_bit = w[23-k];
      end else begin
        exp_vld = 1'b0;
      end
    end
    repeat (HALF) @(negedge clk);
    csb = 1'b1; exp_vld = 1'b0; sdi = 1'b0;
    repeat (2 * HALF) @(negedge clk);
    if (act && !rd && nbits >= 24) mem_m[a] = d;
  endtask

  task automatic wr(input logic [6:0] a, input logic [15:0] d);
    logic [15:0] g;
    frame(1'b0, a, d, 24, g);
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] junk);
    logic [15:0] g;
    frame(1'b1, a, junk, 24, g);
    chk(req, g, mem_m[a]);
  endtask

  initial begin
    logic [15:0] g;
    rst_n = 1'b0; m3 = 0; m4 = 0; od = 0;
    csb = 1'b1; sclk = 1'b0; sdi = 1'b0;
    exp_vld = 1'b0; exp_bit = 1'b0;
    for (int i = 0; i < 3; i++) hist[i] = 2'b00;
    for (int i = 0; i < 128; i++) mem_m[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 reset outputs", {14'd0, oe, sdo}, 16'd0);
    cmp_en = 1;

    // push-pull writes and reads
    cur_req = "R4";
    set_mode(1, 1, 0);
    rd_chk("R8 reset value", 7'h33, 16'h0000);
    wr(7'h12, 16'hA5C3);
    wr(7'h7F, 16'hFFFF);
    wr(7'h00, 16'h8001);
    rd_chk("R1 R2 R4 read 12", 7'h12, 16'h0000);
    rd_chk("R1 R2 R4 read 7F", 7'h7F, 16'h0000);
    rd_chk("R1 R2 R4 read 00", 7'h00, 16'h0000);

    // open-drain reads
    cur_req = "R5";
    set_mode(1, 1, 1);
    rd_chk("R5 od read 12", 7'h12, 16'h0000);
    rd_chk("R5 od read 00", 7'h00, 16'h0000);
    wr(7'h55, 16'h0F0F);
    rd_chk("R5 od read 55", 7'h55, 16'h0000);

    // aborted frames
    cur_req = "R6";
    set_mode(1, 1, 0);
    frame(1'b0, 7'h12, 16'h1111, 20, g);
    rd_chk("R6 partial write ignored", 7'h12, 16'h0000);
    frame(1'b1, 7'h7F, 16'h0000, 12, g);
    rd_chk("R6 read after aborted read", 7'h7F, 16'h0000);

    // data-in toggling during reads
    cur_req = "R7";
    rd_chk("R7 junk ones", 7'h12, 16'hFFFF);
    rd_chk("R7 junk alt", 7'h12, 16'h5A5A);
    rd_chk("R7 contents kept", 7'h12, 16'h0000);

    // overlong frames
    cur_req = "R9";
    frame(1'b0, 7'h21, 16'hC3A5, 30, g);
    rd_chk("R9 overlong write", 7'h21, 16'h0000);
    set_mode(1, 1, 1);
    frame(1'b1, 7'h21, 16'h0000, 28, g);
    chk("R9 overlong read", g, mem_m[7'h21]);

    // other mode settings
    cur_req = "R3";
    set_mode(1, 0, 0);
    wr(7'h12, 16'hDEAD);
    set_mode(0, 1, 1);
    wr(7'h12, 16'hBEEF);
    frame(1'b1, 7'h12, 16'h0000, 24, g);
    set_mode(0, 0, 0);
    wr(7'h44, 16'h1234);
    set_mode(1, 1, 0);
    rd_chk("R3 write ignored 12", 7'h12, 16'h0000);
    rd_chk("R3 write ignored 44", 7'h44, 16'h0000);

    // address sweep
    cur_req = "R1";
    for (int i = 0; i < 8; i++) wr(7'((i * 17 + 3) % 128), 16'((i * 16'h1357) ^ 16'hA0A0));
    for (int i = 0; i < 8; i++) rd_chk("R1 R8 sweep", 7'((i * 17 + 3) % 128), 16'(i));

    cmp_en = 0;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule